// File: doc/BRIEF.md
# Windowed Watchdog Reset Controller

This block watches over an external microcontroller through a windowed watchdog that firmware switches on itself. It drives one active-low reset request. Right after power-on that request is held low for a fixed span. The controller then waits, idle, until firmware writes the enable bit with a 1. From that write on, every further write of 1 is an acknowledge, and each acknowledge restarts the supervision timer. An acknowledge that comes before the minimum spacing is a violation. So is the absence of any acknowledge before the selected timeout. After a violation and a short fixed delay, the block pulls the reset request low for a fixed hold span.

All timing is counted in ticks of a free-running strobe, `tick_i`. The tick period is 0.5 ms, so the 0.5 ms trip delay is one tick. At that period the defaults give the following spans:

| Span | Ticks | Time |
|------|-------|------|
| Minimum acknowledge spacing | 4 | 2 ms |
| Timeout, code 0 | 64 | 32 ms |
| Timeout, highest code | 1024 | 512 ms |
| Reset hold | 200 | 100 ms |

A sticky flag records that the last reset came from the watchdog. Firmware can then tell a warm boot from a cold boot, and reading the flag clears it.

The controller runs as one state machine with five states:

- `WS_POR_HOLD`: reset held after power-on.
- `WS_IDLE`: supervision off.
- `WS_ARMED`: supervising.
- `WS_TRIP`: violation seen, delay running.
- `WS_RST_HOLD`: watchdog reset held.

Its transitions are:

- `WS_POR_HOLD` goes to `WS_IDLE` when the hold span ends.
- `WS_IDLE` goes to `WS_ARMED` on a write of 1.
- `WS_ARMED` goes to `WS_TRIP` on an early acknowledge or a timeout.
- `WS_ARMED` goes to `WS_IDLE` on a write of 0.
- `WS_TRIP` goes to `WS_RST_HOLD` when the delay ends.
- `WS_RST_HOLD` goes to `WS_IDLE` when the hold span ends.

Top module: `wdg_supervisor`

## Requirements
- R1: After power-on reset is released, `wdt_rst_no` stays low until the 200th tick and goes high on that tick; `warm_boot_o` is 0 after power-on.
- R2: While supervision is off, a write with `en_data_i`=0 has no effect. A write with `en_data_i`=1 starts supervision with the timer cleared to zero ticks.
- R3: While supervising, a write of 1 made when fewer than 4 ticks have passed since the last timer clear is a violation. A write of 1 made at exactly 4 ticks or later is accepted and clears the timer.
- R4: While supervising, if no acknowledge is accepted, the tick that brings the elapsed count to the timeout limit is a violation. An acknowledge in the same clock cycle as that tick counts as late. An acknowledge in any earlier cycle is accepted.
- R5: The 3-bit `tmo_sel_i` is captured when supervision starts and at each accepted acknowledge. Code k in 0..4 selects 64·2^k ticks; codes 5 to 7 select 1024 ticks. Changes to `tmo_sel_i` between captures have no effect.
- R6: `wdt_rst_no` falls on the first tick after a violation, stays low for 200 ticks, and rises on the 200th tick of the hold.
- R7: `warm_boot_o` becomes 1 in the cycle after a violation and stays 1 until a `flag_rd_i` strobe clears it. A violation in the same cycle as a read leaves it at 1.
- R8: A watchdog reset turns supervision off. Writes made during the trip delay or the reset hold are ignored, and supervision resumes only after a new write of 1.
- R9: While supervising, a write with `en_data_i`=0 turns supervision off with no reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| tick_i | input | 1 | One-cycle timebase strobe (one per 0.5 ms) |
| en_wr_i | input | 1 | Write strobe for the enable bit |
| en_data_i | input | 1 | Enable bit value written with `en_wr_i` |
| tmo_sel_i | input | 3 | Timeout interval select code |
| flag_rd_i | input | 1 | Read strobe that clears the warm-boot flag |
| wdt_rst_no | output | 1 | Active-low reset request to the microcontroller |
| warm_boot_o | output | 1 | Sticky flag: last reset came from the watchdog |

## Verification
The bench targets the edges of the acknowledge window:

- **Acknowledge at 3 ticks.** This must trip. A design that compared with the wrong inequality would let it pass.
- **Acknowledge at exactly 4 ticks.** This must be accepted. The same wrong comparison would reset here instead.
- **Acknowledge in the same cycle as the timeout tick.** This must reset. A design that gave the acknowledge priority would quietly keep running.
- **Acknowledge one cycle before the timeout tick.** This must be accepted.

Timing is checked to the exact tick. An extra pipeline stage would move the reset fall or rise by one tick, and a wrongly sized select table would move the timeout.

Three ignored-input cases are checked:

- A timeout code changed after it was captured.
- Writes made during the reset hold. A design that kept the enable across its own reset would trip again with no new enable.
- A flag read in the same cycle as a violation. If the read won, the warm-boot evidence would be lost.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    // Supervisor states
    typedef enum logic [2:0] {
        WS_POR_HOLD = 3'd0,
        WS_IDLE     = 3'd1,
        WS_ARMED    = 3'd2,
        WS_TRIP     = 3'd3,
        WS_RST_HOLD = 3'd4
    } wdg_state_e;

    // Timeout in ticks for a select code, saturating at the largest shift
    function automatic int unsigned wdg_code_limit(
        input int unsigned code,
        input int unsigned base_ticks,
        input int unsigned max_shift
    );
        int unsigned sh;
        sh = (code > max_shift) ? max_shift : code;
        return base_ticks << sh;
    endfunction

endpackage

// File: rtl/wdg_span_counter.sv
// Counts ticks while run_i is high and flags the tick that completes SPAN.
// The count returns to zero whenever run_i is low.
module wdg_span_counter #(
    parameter int unsigned SPAN = 200
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic run_i,
    input  logic tick_i,
    output logic done_o
);
    localparam int unsigned CW = (SPAN > 1) ? $clog2(SPAN) : 1;
    localparam logic [CW-1:0] LAST = CW'(SPAN - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else if (!run_i) begin
            cnt_q <= '0;
        end else if (tick_i) begin
            if (cnt_q == LAST) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign done_o = run_i && tick_i && (cnt_q == LAST);

    // The count never reaches the span itself (R6)
    assert_span_bound_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_q <= LAST);

endmodule

// File: rtl/wdg_tick_timer.sv
// Ticks elapsed since the last clear, saturating at all ones.
module wdg_tick_timer #(
    parameter int unsigned CNT_W = 11
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             clr_i,
    input  logic             tick_i,
    output logic [CNT_W-1:0] elapsed_o
);
    logic [CNT_W-1:0] elapsed_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            elapsed_q <= '0;
        end else if (clr_i) begin
            elapsed_q <= '0;
        end else if (tick_i && (elapsed_q != {CNT_W{1'b1}})) begin
            elapsed_q <= elapsed_q + 1'b1;
        end
    end

    assign elapsed_o = elapsed_q;

endmodule

// File: rtl/wdg_limit_reg.sv
// Captures the timeout limit for the select code on load_i.
module wdg_limit_reg
    import wdg_pkg::*;
#(
    parameter int unsigned BASE_TICKS = 64,
    parameter int unsigned MAX_SHIFT  = 4,
    parameter int unsigned SEL_W      = 3,
    parameter int unsigned CNT_W      = 11
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             load_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic [CNT_W-1:0] limit_o
);
    localparam int unsigned NUM_CODES = 1 << SEL_W;

    logic [CNT_W-1:0] cand [NUM_CODES];
    logic [CNT_W-1:0] limit_q;

    for (genvar g = 0; g < NUM_CODES; g++) begin : g_code
        localparam int unsigned LIM = wdg_code_limit(g, BASE_TICKS, MAX_SHIFT);
        assign cand[g] = CNT_W'(LIM);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            limit_q <= CNT_W'(BASE_TICKS);
        end else if (load_i) begin
            limit_q <= cand[sel_i];
        end
    end

    assign limit_o = limit_q;

endmodule

// File: rtl/wdg_window.sv
// Classifies the current cycle while supervising: early acknowledge,
// timeout (late), or accepted acknowledge. A timeout tick wins over an ack.
module wdg_window #(
    parameter int unsigned EARLY_TICKS = 4,
    parameter int unsigned CNT_W       = 11
) (
    input  logic             armed_i,
    input  logic             ack_i,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] elapsed_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic             early_o,
    output logic             late_o,
    output logic             ok_o
);
    localparam logic [CNT_W-1:0] EARLY_LIM = CNT_W'(EARLY_TICKS);

    logic last_tick;
    logic too_soon;

    always_comb begin
        last_tick = tick_i && (elapsed_i == (limit_i - 1'b1));
        too_soon  = (elapsed_i < EARLY_LIM);
        late_o    = armed_i && last_tick;
        early_o   = armed_i && ack_i && !last_tick && too_soon;
        ok_o      = armed_i && ack_i && !last_tick && !too_soon;
    end

endmodule

// File: rtl/wdg_supervisor.sv
module wdg_supervisor
    import wdg_pkg::*;
#(
    parameter int unsigned EARLY_TICKS      = 4,
    parameter int unsigned BASE_TICKS       = 64,
    parameter int unsigned MAX_SHIFT        = 4,
    parameter int unsigned SEL_W            = 3,
    parameter int unsigned TRIP_DELAY_TICKS = 1,
    parameter int unsigned HOLD_TICKS       = 200
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             tick_i,
    input  logic             en_wr_i,
    input  logic             en_data_i,
    input  logic [SEL_W-1:0] tmo_sel_i,
    input  logic             flag_rd_i,
    output logic             wdt_rst_no,
    output logic             warm_boot_o
);
    localparam int unsigned MAX_LIMIT = BASE_TICKS << MAX_SHIFT;
    localparam int unsigned CNT_W     = $clog2(MAX_LIMIT + 1);

    wdg_state_e       state_q, state_d;
    logic             arm_req, dis_req, in_armed;
    logic             early, late, ack_ok, viol;
    logic             hold_run, hold_done, dly_run, dly_done;
    logic             timer_clr, limit_load;
    logic [CNT_W-1:0] elapsed, limit;
    logic             warm_q;

    assign arm_req  = en_wr_i && en_data_i;
    assign dis_req  = en_wr_i && !en_data_i;
    assign in_armed = (state_q == WS_ARMED);
    assign viol     = early || late;

    // Timer clears whenever supervision is off or an ack is accepted
    assign timer_clr  = !in_armed || ack_ok;
    assign limit_load = ((state_q == WS_IDLE) && arm_req) || ack_ok;
    assign hold_run   = (state_q == WS_POR_HOLD) || (state_q == WS_RST_HOLD);
    assign dly_run    = (state_q == WS_TRIP);

    wdg_tick_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .clr_i     (timer_clr),
        .tick_i    (tick_i),
        .elapsed_o (elapsed)
    );

    wdg_limit_reg #(
        .BASE_TICKS (BASE_TICKS),
        .MAX_SHIFT  (MAX_SHIFT),
        .SEL_W      (SEL_W),
        .CNT_W      (CNT_W)
    ) u_limit (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .load_i  (limit_load),
        .sel_i   (tmo_sel_i),
        .limit_o (limit)
    );

    wdg_window #(
        .EARLY_TICKS (EARLY_TICKS),
        .CNT_W       (CNT_W)
    ) u_window (
        .armed_i   (in_armed),
        .ack_i     (arm_req),
        .tick_i    (tick_i),
        .elapsed_i (elapsed),
        .limit_i   (limit),
        .early_o   (early),
        .late_o    (late),
        .ok_o      (ack_ok)
    );

    wdg_span_counter #(
        .SPAN (TRIP_DELAY_TICKS)
    ) u_delay (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .run_i  (dly_run),
        .tick_i (tick_i),
        .done_o (dly_done)
    );

    wdg_span_counter #(
        .SPAN (HOLD_TICKS)
    ) u_hold (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .run_i  (hold_run),
        .tick_i (tick_i),
        .done_o (hold_done)
    );

    // State register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= WS_POR_HOLD;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WS_POR_HOLD: if (hold_done) state_d = WS_IDLE;
            WS_IDLE:     if (arm_req)   state_d = WS_ARMED;
            WS_ARMED: begin
                if (viol) begin
                    state_d = WS_TRIP;
                end else if (dis_req) begin
                    state_d = WS_IDLE;
                end
            end
            WS_TRIP:     if (dly_done)  state_d = WS_RST_HOLD;
            WS_RST_HOLD: if (hold_done) state_d = WS_IDLE;
            default:     state_d = WS_POR_HOLD;
        endcase
    end

    // Output decode
    always_comb begin
        wdt_rst_no = 1'b1;
        unique case (state_q)
            WS_POR_HOLD, WS_RST_HOLD: wdt_rst_no = 1'b0;
            default:                  wdt_rst_no = 1'b1;
        endcase
    end

    // Warm-boot flag: a violation wins over a read in the same cycle
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            warm_q <= 1'b0;
        end else if (viol) begin
            warm_q <= 1'b1;
        end else if (flag_rd_i) begin
            warm_q <= 1'b0;
        end
    end

    assign warm_boot_o = warm_q;

    assert_idle_zero_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == WS_IDLE && dis_req) |=> (state_q == WS_IDLE));

    assert_early_ack_trips_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == WS_ARMED && arm_req && elapsed < CNT_W'(EARLY_TICKS)
         && !(tick_i && elapsed == limit - 1'b1)) |=> (state_q == WS_TRIP));

    assert_late_trips_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == WS_ARMED && tick_i && elapsed == limit - 1'b1)
        |=> (state_q == WS_TRIP && warm_boot_o));

    assert_elapsed_below_limit_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == WS_ARMED) |-> (elapsed < limit));

    assert_release_on_tick_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(wdt_rst_no) |-> $past(tick_i));

    assert_read_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (flag_rd_i && !viol) |=> !warm_boot_o);

    assert_release_unarmed_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(wdt_rst_no) |-> (state_q == WS_IDLE));

    assert_disable_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == WS_ARMED && dis_req && !viol) |=> (state_q == WS_IDLE && wdt_rst_no));

endmodule

// File: tb/wdg_supervisor_tb.sv
module wdg_supervisor_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_i = 1'b0;
    logic       en_wr_i = 1'b0;
    logic       en_data_i = 1'b0;
    logic [2:0] tmo_sel_i = 3'd0;
    logic       flag_rd_i = 1'b0;
    logic       wdt_rst_no;
    logic       warm_boot_o;

    int compared = 0;
    int mismatched = 0;
    int tick_no = 0;
    bit finished = 0;

    typedef struct {
        bit    lvl;
        int    tick;
        bit    warm;
        string req;
    } ev_t;

    ev_t exp_q[$];

    always #5 clk = ~clk;

    wdg_supervisor u_dut (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .tick_i      (tick_i),
        .en_wr_i     (en_wr_i),
        .en_data_i   (en_data_i),
        .tmo_sel_i   (tmo_sel_i),
        .flag_rd_i   (flag_rd_i),
        .wdt_rst_no  (wdt_rst_no),
        .warm_boot_o (warm_boot_o)
    );

    // Timebase: one tick every 4 clocks, driven at the falling edge
    initial begin
        int ph = 0;
        forever begin
            @(negedge clk);
            tick_i <= (ph == 3);
            ph = (ph + 1) % 4;
        end
    end

    always @(posedge clk) begin
        if (rst_n && tick_i) tick_no++;
    end

    // Monitor: compares each reset edge with the next expected item
    initial begin
        logic prev = 1'b0;
        forever begin
            @(negedge clk);
            if (rst_n && (wdt_rst_no !== prev)) begin
                if (exp_q.size() == 0) begin
                    compared++;
                    mismatched++;
                    $display("FAIL R2 R8 R9 unexpected edge: actual level %b at tick %0d, expected none",
                             wdt_rst_no, tick_no);
                end else begin
                    ev_t ev;
                    ev = exp_q.pop_front();
                    compared++;
                    if (wdt_rst_no !== ev.lvl || tick_no != ev.tick || warm_boot_o !== ev.warm) begin
                        mismatched++;
                        $display("FAIL %s edge: actual lvl=%b tick=%0d warm=%b, expected lvl=%b tick=%0d warm=%b",
                                 ev.req, wdt_rst_no, tick_no, warm_boot_o, ev.lvl, ev.tick, ev.warm);
                    end
                end
                prev = wdt_rst_no;
            end
        end
    end

    task automatic expect_ev(input bit lvl, input int tick, input bit warm, input string req);
        ev_t ev;
        ev.lvl = lvl; ev.tick = tick; ev.warm = warm; ev.req = req;
        exp_q.push_back(ev);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %0d, expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_tick(input int n);
        while (tick_no < n) @(negedge clk);
    endtask

    // Write issued in the cycle after the current tick (never a tick cycle)
    task automatic write_en(input bit d);
        en_data_i = d;
        en_wr_i   = 1'b1;
        @(negedge clk);
        en_wr_i   = 1'b0;
    endtask

    // Write issued in the same clock cycle as tick number n
    task automatic write_on_tick(input int n, input bit d);
        wait_tick(n - 1);
        forever begin
            @(negedge clk);
            #1;
            if (tick_i) break;
        end
        en_data_i = d;
        en_wr_i   = 1'b1;
        @(negedge clk);
        en_wr_i   = 1'b0;
    endtask

    task automatic read_flag(input string req);
        chk(req, warm_boot_o, 1);
        flag_rd_i = 1'b1;
        @(negedge clk);
        flag_rd_i = 1'b0;
        chk(req, warm_boot_o, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 reset low", wdt_rst_no, 0);
        chk("R1 cold flag", warm_boot_o, 0);
        expect_ev(1, 200, 0, "R1");
        rst_n = 1'b1;
        wait_tick(100);
        chk("R1 still held", wdt_rst_no, 0);
        wait_tick(210);

        // R2: write of 0 while idle does nothing
        write_en(0);
        wait_tick(300);
        chk("R2 no supervision", wdt_rst_no, 1);

        // R4/R6: plain timeout with code 0 (64 ticks)
        tmo_sel_i = 3'd0;
        expect_ev(0, 365, 1, "R4 R6 timeout fall");
        expect_ev(1, 565, 1, "R6 hold release");
        write_en(1);
        wait_tick(570);
        read_flag("R7 read clears");

        // R8: supervision is off after a watchdog reset
        wait_tick(650);
        chk("R8 stays off", wdt_rst_no, 1);

        // R3: ack after 3 ticks trips; write during hold ignored (R8)
        wait_tick(660);
        write_en(1);
        expect_ev(0, 664, 1, "R3 early fall");
        expect_ev(1, 864, 1, "R3 R6 release");
        wait_tick(663);
        write_en(1);
        wait_tick(700);
        write_en(1);
        wait_tick(870);
        read_flag("R7 read after early");
        wait_tick(934);
        chk("R8 hold write ignored", wdt_rst_no, 1);

        // R3: ack at exactly 4 ticks accepted, acks restart the timer
        wait_tick(940);
        write_en(1);
        wait_tick(944);
        write_en(1);
        wait_tick(1004);
        write_en(1);
        wait_tick(1067);
        write_en(1);
        expect_ev(0, 1132, 1, "R3 R4 after acks fall");
        expect_ev(1, 1332, 1, "R6 release");
        wait_tick(1340);
        read_flag("R7 read");

        // R4: ack in the timeout tick cycle counts as late
        wait_tick(1350);
        write_en(1);
        expect_ev(0, 1415, 1, "R4 same-tick late fall");
        expect_ev(1, 1615, 1, "R6 release");
        write_on_tick(1414, 1);
        wait_tick(1616);
        read_flag("R7 read");

        // R4 boundary: ack at 63 ticks accepted; R9 disable
        wait_tick(1620);
        write_en(1);
        wait_tick(1683);
        write_en(1);
        wait_tick(1693);
        write_en(0);
        wait_tick(1793);
        chk("R9 disabled no reset", wdt_rst_no, 1);
        chk("R4 no flag", warm_boot_o, 0);

        // R5: code 1 gives 128 ticks
        wait_tick(1800);
        tmo_sel_i = 3'd1;
        write_en(1);
        expect_ev(0, 1929, 1, "R5 code1 fall");
        expect_ev(1, 2129, 1, "R6 release");
        wait_tick(2130);
        read_flag("R7 read");

        // R5: code 7 saturates to 1024; later select change ignored
        wait_tick(2140);
        tmo_sel_i = 3'd7;
        write_en(1);
        wait_tick(2150);
        tmo_sel_i = 3'd0;
        expect_ev(0, 3165, 1, "R5 saturate fall");
        expect_ev(1, 3365, 1, "R6 release");
        wait_tick(3366);
        read_flag("R7 read");

        // R5: select captured at an accepted ack (code 2 = 256)
        wait_tick(3370);
        tmo_sel_i = 3'd0;
        write_en(1);
        wait_tick(3380);
        tmo_sel_i = 3'd2;
        wait_tick(3400);
        write_en(1);
        expect_ev(0, 3657, 1, "R5 ack capture fall");
        expect_ev(1, 3857, 1, "R6 release");
        wait_tick(3858);
        read_flag("R7 read");

        // R7: violation and read in the same cycle leave the flag set
        wait_tick(3860);
        tmo_sel_i = 3'd0;
        write_en(1);
        expect_ev(0, 3863, 1, "R7 set wins fall");
        expect_ev(1, 4063, 1, "R6 release");
        wait_tick(3862);
        en_data_i = 1'b1;
        en_wr_i   = 1'b1;
        flag_rd_i = 1'b1;
        @(negedge clk);
        en_wr_i   = 1'b0;
        flag_rd_i = 1'b0;
        chk("R7 set wins over read", warm_boot_o, 1);
        wait_tick(4070);
        read_flag("R7 final read");

        chk("R6 all edges seen", exp_q.size(), 0);
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            compared++;
            mismatched++;
            $display("FAIL watchdog: actual tick %0d, expected run to complete", tick_no);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule